// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Controller

This block is a compact 16-bit processor core. A finite state machine steps every instruction through a fixed fetch sequence and a one-cycle decode. It then walks through only those later phases the opcode needs: address evaluation, operand fetch, execute and result store. Four opcodes are recognised:

- a register-to-register add;
- a load from a base register plus a signed 6-bit offset;
- a jump to the address held in a register;
- a halt.

Any other opcode decodes to a no-op. The core keeps an eight-entry register file, a program counter, a memory address register, a memory data register and an instruction register. Transfers between them pass over one internal bus whose drivers are gated one at a time.

The core reaches memory through a single-port word interface. Read data must be valid in the same cycle that the read strobe is high, and the core captures it at the end of that cycle. A run flag acts as the clock enable of every core register. The halt instruction clears the flag, which freezes the machine with its fetch state ready. A one-cycle pulse on `start` sets the flag again, and fetching resumes at the word after the halt.

Top module: `mc_core`

## Requirements
- R1: While reset is low, all core registers are zero and the run flag is set: `halted`=0, `mem_rd`=0, `mem_we`=0 and `mem_addr`=0. The first fetch after reset reads address 0 in the second cycle.
- R2: The fetch sequence takes three cycles. In cycle 1 the address register takes the PC over the bus and the PC increments. In cycle 2 `mem_rd`=1 with `mem_addr` equal to the old PC, and the data register loads. In cycle 3 the instruction register loads from the data register.
- R3: Decode takes one cycle and dispatches on instruction bits 15:12. The codes are 0001 add, 0110 load, 1100 jump and 1111 halt. Any other code returns to fetch, so such an instruction lasts 4 cycles.
- R4: Add writes `R[ir[8:6]] + R[ir[2:0]]` (mod 2^16) into `R[ir[11:9]]`, in 5 cycles in total.
- R5: Load drives `mem_addr` = `R[ir[8:6]]` + sign-extended `ir[5:0]` with `mem_rd`=1 in its 6th cycle, and writes the word read into `R[ir[11:9]]`. It takes 7 cycles in total.
- R6: Jump loads the PC from `R[ir[8:6]]` in its 5th cycle, so the next fetch reads that address.
- R7: Halt clears the run flag at the end of its 5th cycle. From then on, `halted`=1, `mem_rd` stays 0 and `mem_addr` holds its value.
- R8: A one-cycle `start` pulse while halted sets the run flag. Fetch then resumes at the address after the halt word, with its read 2 cycles after the pulse.
- R9: If `start` is high in the same cycle that halt clears the run flag, setting wins: `halted` stays 0 and the next fetch follows at once.
- R10: `mem_we` is never asserted, because the core issues only reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sets the run flag |
| mem_rdata | input | 16 | Read word, valid in the cycle `mem_rd` is high |
| mem_addr | output | 16 | Word address (the memory address register) |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe (held low) |
| mem_wdata | output | 16 | Write word (the memory data register) |
| halted | output | 1 | Run flag is clear |

## Verification
The two events that can fall in the same cycle are the halt state clearing the run flag and an external `start` setting it. The bench first runs a program to its halt and restarts it. On the second pass, it raises `start` exactly in the halt state's cycle. The collision is judged at the ports: `halted` must read 0 in that cycle and the next one, and the fetch of the word after the halt must appear on the memory bus two cycles later. An isolated restart checked earlier gives the baseline timing.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int XLEN = 16;
  typedef logic [XLEN-1:0] word_t;

  localparam logic [3:0] OP_ADD  = 4'b0001;
  localparam logic [3:0] OP_LDR  = 4'b0110;
  localparam logic [3:0] OP_JMP  = 4'b1100;
  localparam logic [3:0] OP_HALT = 4'b1111;

  typedef enum logic [3:0] {
    S_F1    = 4'd1,
    S_F2    = 4'd2,
    S_F3    = 4'd3,
    S_DEC   = 4'd4,
    S_ADD   = 4'd5,
    S_LD_EA = 4'd6,
    S_LD_RD = 4'd7,
    S_LD_WB = 4'd8,
    S_JMP   = 4'd9,
    S_HALT  = 4'd10
  } state_t;

  typedef struct packed {
    logic g_pc;
    logic g_mdr;
    logic g_ea;
    logic g_alu;
    logic ld_mar;
    logic ld_pc;
    logic pc_jmp;
    logic ld_mdr;
    logic ld_ir;
    logic rf_we;
    logic mem_rd;
    logic halt_clr;
  } ctl_t;

  function automatic word_t pc_next(input word_t pc);
    return pc + word_t'(1);
  endfunction

  function automatic word_t sext6(input logic [5:0] v);
    return {{(XLEN-6){v[5]}}, v};
  endfunction

  function automatic word_t ea_calc(input word_t base, input logic [5:0] off);
    return base + sext6(off);
  endfunction

  function automatic word_t alu_add(input word_t a, input word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_runlatch.sv
module mc_runlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic run
);
  // setting has priority over clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= 1'b1;
    else if (set_req) run <= 1'b1;
    else if (clr_req) run <= 1'b0;
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce,
  input  logic [3:0] opcode,
  output state_t     state_q,
  output ctl_t       ctl
);
  state_t nxt;

  always_comb begin
    ctl = '0;
    nxt = S_F1;
    unique case (state_q)
      S_F1:    begin ctl.g_pc = 1'b1; ctl.ld_mar = 1'b1; ctl.ld_pc = 1'b1; nxt = S_F2; end
      S_F2:    begin ctl.mem_rd = 1'b1; ctl.ld_mdr = 1'b1; nxt = S_F3; end
      S_F3:    begin ctl.g_mdr = 1'b1; ctl.ld_ir = 1'b1; nxt = S_DEC; end
      S_DEC: begin
        case (opcode)
          OP_ADD:  nxt = S_ADD;
          OP_LDR:  nxt = S_LD_EA;
          OP_JMP:  nxt = S_JMP;
          OP_HALT: nxt = S_HALT;
          default: nxt = S_F1;
        endcase
      end
      S_ADD:   begin ctl.g_alu = 1'b1; ctl.rf_we = 1'b1; end
      S_LD_EA: begin ctl.g_ea = 1'b1; ctl.ld_mar = 1'b1; nxt = S_LD_RD; end
      S_LD_RD: begin ctl.mem_rd = 1'b1; ctl.ld_mdr = 1'b1; nxt = S_LD_WB; end
      S_LD_WB: begin ctl.g_mdr = 1'b1; ctl.rf_we = 1'b1; end
      S_JMP:   begin ctl.ld_pc = 1'b1; ctl.pc_jmp = 1'b1; end
      S_HALT:  ctl.halt_clr = 1'b1;
      default: nxt = S_F1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= S_F1;
    else if (ce) state_q <= nxt;
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int    NREG     = 8,
  parameter word_t RESET_PC = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  output logic        halted
);
  localparam int RAW = $clog2(NREG);

  word_t  pc_q, mar_q, mdr_q, ir_q, bus;
  word_t  rd1, rd2, ea_val, alu_val;
  logic   run;
  ctl_t   ctl;
  state_t state_q;
  logic [3:0] gates;

  mc_runlatch u_run (
    .clk(clk), .rst_n(rst_n), .set_req(start), .clr_req(ctl.halt_clr), .run(run)
  );

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(run), .opcode(ir_q[15:12]),
    .state_q(state_q), .ctl(ctl)
  );

  mc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(run & ctl.rf_we),
    .wa(ir_q[9 +: RAW]), .wd(bus),
    .ra1(ir_q[6 +: RAW]), .ra2(ir_q[0 +: RAW]),
    .rd1(rd1), .rd2(rd2)
  );

  assign ea_val  = ea_calc(rd1, ir_q[5:0]);
  assign alu_val = alu_add(rd1, rd2);
  assign gates   = {ctl.g_pc, ctl.g_mdr, ctl.g_ea, ctl.g_alu};

  always_comb begin
    bus = '0;
    if (ctl.g_pc)  bus = pc_q;
    if (ctl.g_mdr) bus = mdr_q;
    if (ctl.g_ea)  bus = ea_val;
    if (ctl.g_alu) bus = alu_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else if (run) begin
      if (ctl.ld_mar) mar_q <= bus;
      if (ctl.ld_pc)  pc_q  <= ctl.pc_jmp ? rd1 : pc_next(pc_q);
      if (ctl.ld_mdr) mdr_q <= mem_rdata;
      if (ctl.ld_ir)  ir_q  <= bus;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_we    = 1'b0;
  assign mem_wdata = mdr_q;
  assign halted    = ~run;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        run,
  input logic        mem_rd,
  input state_t      st,
  input logic [15:0] pc,
  input logic [15:0] ir,
  input logic [15:0] mdr,
  input logic [15:0] jmp_base,
  input logic [3:0]  gates
);
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_F1 |=> st == S_F2); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_F1 |=> pc == $past(pc) + 16'd1); // R2
  AST_IR_FROM_MDR: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_F3 |=> ir == $past(mdr)); // R2
  AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gates)); // R2
  AST_DECODE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_DEC |=> st != S_DEC && st != S_F2 && st != S_F3); // R3
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_JMP |=> pc == $past(jmp_base)); // R6
  AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_rd); // R7
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc) && $stable(st)); // R7
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    run && st == S_HALT && !start |=> !run); // R7
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run); // R8
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .mem_rd(mem_rd),
  .st(state_q), .pc(pc_q), .ir(ir_q), .mdr(mdr_q), .jmp_base(rd1), .gates(gates)
);

// File: tb/mc_core_test.sv
module mc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] mem_rdata, mem_addr, mem_wdata;
  logic        mem_rd, mem_we, halted;

  always #10 clk = ~clk;

  logic [15:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];

  mc_core uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .halted(halted)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected read strobes: {cycle, address}, cycle 0 = first cycle after reset
  localparam int NEXP = 19;
  localparam logic [31:0] EXP [NEXP] = '{
    {16'd1,   16'h0000}, {16'd5,   16'h001E}, {16'd8,   16'h0001},
    {16'd12,  16'h001F}, {16'd15,  16'h0002}, {16'd20,  16'h0003},
    {16'd24,  16'h0000}, {16'd27,  16'h0004}, {16'd32,  16'h0005},
    {16'd36,  16'h0006}, {16'd41,  16'h0010}, {16'd46,  16'h0011},
    {16'd50,  16'h620E}, {16'd53,  16'h0012}, {16'd72,  16'h0013},
    {16'd77,  16'h0000}, {16'd129, 16'h0012}, {16'd134, 16'h0013},
    {16'd139, 16'h0000}
  };

  logic        log_rd   [256];
  logic [15:0] log_addr [256];
  logic        log_halt [256];
  int          cyc = 0;
  int          we_seen = 0;
  logic        logging = 1'b1;

  always @(negedge clk) begin
    if (rst_n && logging) begin
      if (cyc < 256) begin
        log_rd[cyc]   = mem_rd;
        log_addr[cyc] = mem_addr;
        log_halt[cyc] = halted;
      end
      if (mem_we !== 1'b0) we_seen++;
      cyc++;
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h00] = 16'h621E; // load R1 <- [R0+30]
    mem[8'h01] = 16'h641F; // load R2 <- [R0+31]
    mem[8'h02] = 16'h1642; // R3 = R1 + R2 = 8
    mem[8'h03] = 16'h68F8; // load R4 <- [R3-8] = [0]
    mem[8'h04] = 16'h1AC3; // R5 = R3 + R3 = 0x10
    mem[8'h05] = 16'h0000; // undefined opcode, no-op
    mem[8'h06] = 16'hC140; // jump R5
    mem[8'h10] = 16'h1D05; // R6 = R4 + R5 = 0x622E
    mem[8'h11] = 16'h6FA0; // load R7 <- [R6-32] = [0x620E]
    mem[8'h12] = 16'hF000; // halt
    mem[8'h13] = 16'hC1C0; // jump R7 (=0)
    mem[8'h1E] = 16'h0005;
    mem[8'h1F] = 16'h0003;

    #15;
    chk("R1 mem_rd in reset", {31'd0, mem_rd}, 32'd0);
    chk("R1 halted in reset", {31'd0, halted}, 32'd0);
    chk("R1 mem_we in reset", {31'd0, mem_we}, 32'd0);
    chk("R1 mem_addr in reset", {16'd0, mem_addr}, 32'd0);

    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;

    repeat (70) @(posedge clk);
    #2 start = 1'b1;          // lone restart pulse in cycle 70
    @(posedge clk);
    #2 start = 1'b0;
    repeat (61) @(posedge clk);
    #2 start = 1'b1;          // pulse in cycle 132, the halt state's cycle
    @(posedge clk);
    #2 start = 1'b0;
    repeat (70) @(posedge clk);
    logging = 1'b0;

    for (int k = 0; k < NEXP; k++) begin
      chk($sformatf("R2 R3 R4 R5 R6 read strobe entry %0d", k),
          {31'd0, log_rd[EXP[k][31:16]]}, 32'd1);
      chk($sformatf("R2 R3 R4 R5 R6 read address entry %0d", k),
          {16'd0, log_addr[EXP[k][31:16]]}, {16'd0, EXP[k][15:0]});
    end

    chk("R3 no-op fetch to next fetch spacing", {31'd0, log_rd[33] | log_rd[34] | log_rd[35]}, 32'd0);
    chk("R7 halted low in halt state", {31'd0, log_halt[56]}, 32'd0);
    chk("R7 halted after halt", {31'd0, log_halt[57]}, 32'd1);
    chk("R7 still halted before start", {31'd0, log_halt[70]}, 32'd1);
    begin
      int reads = 0;
      for (int c = 57; c <= 71; c++) reads += int'(log_rd[c]);
      chk("R7 no reads while halted", reads, 0);
    end
    chk("R7 address held while halted", {16'd0, log_addr[70]}, 32'h0012);
    chk("R8 running after start", {31'd0, log_halt[71]}, 32'd0);
    chk("R9 not halted in collision cycle", {31'd0, log_halt[132]}, 32'd0);
    chk("R9 not halted after collision", {31'd0, log_halt[133]}, 32'd0);
    chk("R7 third pass halts", {31'd0, log_halt[195]}, 32'd1);
    chk("R10 write strobe never seen", we_seen, 0);

    rst_n = 1'b0;
    #1;
    chk("R1 halted cleared by reset", {31'd0, halted}, 32'd0);
    chk("R1 address cleared by reset", {16'd0, mem_addr}, 32'd0);
    chk("R1 no read in reset", {31'd0, mem_rd}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule